// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a free-running cycle counter with a one-shot compare match. A 63-bit count advances by one on every cycle where the tick enable is high. The enable stands for the counter's 100 MHz time base. Software reaches the block through one write port that selects either the count word or the limit word, and through a read port that always shows the count word. The top bit of each word is a control flag and not part of the value. In the count word it is an access-trap flag, which is stored and reflected on reads. In the limit word it is an interrupt-disable flag.

A limit write arms a single match when its disable flag is clear and its compare value is nonzero. On the first plain tick at which the advanced count is at or past the compare value, the block sets a sticky soft-interrupt bit and gives a one-cycle wake pulse. The match then disarms. The same block is instantiated three times: once for the processor tick, once for the system tick and once for the hypervisor system tick. Each instance's soft bit feeds the matching bit of the processor's soft-interrupt register.

Top module: `tick_timer`

## Requirements
- R1: After reset the read word is 0x8000_0000_0000_0000 (trap flag set, count zero), softIrq is 0 and wakePulse is 0.
- R2: In each cycle with tickEn high and wrEn low, the count grows by one. With tickEn low it holds. It wraps from 2^63-1 to 0, and the trap flag (bit 63) is unchanged by the wrap.
- R3: A count write (wrEn=1, wrSel=0) loads bits 62:0 into the count and bit 63 into the trap flag. The read word is {trap flag, count}. A write in a cycle with tickEn high replaces that cycle's increment.
- R4: A limit write (wrEn=1, wrSel=1) takes bit 63 as the disable flag and bits 62:0 as the compare value. It arms a match only if the flag is 0 and the compare value is nonzero.
- R5: While armed, the first cycle with tickEn high and wrEn low in which count+1 is at or above the compare value fires the match. From the next cycle softIrq is 1 and wakePulse is 1 for exactly one cycle. The match then disarms and does not fire again without a new limit write.
- R6: A compare value already below the current count when written fires on the next tick.
- R7: A compare value of zero or a set disable flag never fires. Such a write also cancels a match that is already armed.
- R8: softIrq stays 1 until softClr is pulsed, and a limit write does not clear it. If a match and softClr fall in the same cycle, softIrq ends up 1.
- R9: Reset cancels an armed match. Until the next limit write, no tick produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Advance the count this cycle |
| wrEn | input | 1 | Software write strobe |
| wrSel | input | 1 | 0 selects the count word, 1 selects the limit word |
| wrData | input | 64 | Write word; bit 63 is the flag for the selected word |
| softClr | input | 1 | Software clear of the soft-interrupt bit |
| rdData | output | 64 | Count word: {trap flag, 63-bit count} |
| softIrq | output | 1 | Sticky soft-interrupt bit for this instance |
| wakePulse | output | 1 | One-cycle wake request to the processor on a match |

## Verification
Two pairs of events can fall on the same edge. A software write can coincide with a tick, and a match can coincide with a software clear of the soft bit. The bench holds tickEn high through a count write and confirms that the read word equals the written value with no extra increment. It also raises softClr on exactly the tick at which count+1 reaches the compare value, and requires softIrq to read 1 afterwards. A further clear then takes softIrq back to 0.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic loadCnt;  // replace count and trap flag with write data
    logic loadLim;  // replace compare value
    logic step;     // advance count by one
  } tickStrobe_t;
endpackage

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobe_t      strb,
  input  logic [CNT_W:0]   wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic             trapFlag,
  output logic             reached
);
  logic [CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0] cntNext;

  assign cntNext = cntVal + {{(CNT_W-1){1'b0}}, 1'b1};
  assign reached = (cntNext >= cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      trapFlag <= 1'b1;
    end else if (strb.loadCnt) begin
      cntVal   <= wrData[CNT_W-1:0];
      trapFlag <= wrData[CNT_W];
    end else if (strb.step) begin
      cntVal   <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmpVal <= '0;
    else if (strb.loadLim) cmpVal <= wrData[CNT_W-1:0];
  end

  // R2: a plain step advances the count by exactly one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.loadCnt) |=> (cntVal == $past(cntVal) + 1'b1));

  // R3: a count load takes both the value and the flag
  a_r3_count_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (cntVal == $past(wrData[CNT_W-1:0]) && trapFlag == $past(wrData[CNT_W])));

  // R2: no strobe leaves the count alone
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadCnt && !strb.step) |=> $stable(cntVal));
endmodule

// File: rtl/tick_ctl.sv
module tick_ctl
  import tick_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           tickEn,
  input  logic           wrEn,
  input  logic           wrSel,
  input  logic [CNT_W:0] wrData,
  input  logic           softClr,
  input  logic           reached,
  output tickStrobe_t    strb,
  output logic           softIrq,
  output logic           wakePulse
);
  logic armed;
  logic fire;
  logic armReq;

  always_comb begin
    strb.loadCnt = wrEn && !wrSel;
    strb.loadLim = wrEn && wrSel;
    strb.step    = tickEn && !wrEn;
  end

  // a limit write arms only with the disable flag clear and a nonzero compare
  assign armReq = !wrData[CNT_W] && (wrData[CNT_W-1:0] != '0);
  assign fire   = armed && strb.step && reached;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             armed <= 1'b0;
    else if (strb.loadLim) armed <= armReq;
    else if (fire)         armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softIrq   <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= fire;
      if (fire)         softIrq <= 1'b1;
      else if (softClr) softIrq <= 1'b0;
    end
  end

  // R5: a wake always comes with the soft bit
  a_r5_wake_with_soft: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> softIrq);

  // R5: the wake is a single-cycle pulse
  a_r5_wake_single: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R7: a disabled or zero limit write leaves nothing armed
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && (wrData[CNT_W] || wrData[CNT_W-1:0] == '0)) |=> !armed);

  // R8: the soft bit only falls through a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (softIrq && !softClr) |=> softIrq);

  // R3: no match is taken in a write cycle
  a_r3_no_fire_on_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wakePulse);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 63,
  localparam int WORD_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic              softClr,
  output logic [WORD_W-1:0] rdData,
  output logic              softIrq,
  output logic              wakePulse
);
  tickStrobe_t      strb;
  logic [CNT_W-1:0] cntVal;
  logic             trapFlag;
  logic             reached;

  tick_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .softClr(softClr), .reached(reached), .strb(strb),
    .softIrq(softIrq), .wakePulse(wakePulse)
  );

  tick_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cntVal(cntVal), .trapFlag(trapFlag), .reached(reached)
  );

  assign rdData = {trapFlag, cntVal};
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [63:0] wrData = '0;
  logic        softClr = 1'b0;
  logic [63:0] rdData;
  logic        softIrq;
  logic        wakePulse;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .softClr(softClr), .rdData(rdData),
    .softIrq(softIrq), .wakePulse(wakePulse)
  );

  localparam int NV = 5;
  localparam logic [63:0] V_WR  [NV] = '{64'h0000_0000_0000_0010, 64'h8000_0000_0000_0100,
                                        64'h7FFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'h0000_0000_0000_0000};
  localparam int          V_TK  [NV] = '{5, 3, 3, 1, 0};
  localparam logic [63:0] V_EXP [NV] = '{64'h0000_0000_0000_0015, 64'h8000_0000_0000_0103,
                                        64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
                                        64'h0000_0000_0000_0000};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic clr();
    @(negedge clk);
    softClr = 1'b1;
    @(negedge clk);
    softClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 read", rdData, 64'h8000_0000_0000_0000);
    chk("R1 soft", {63'd0, softIrq}, 64'd0);
    chk("R1 wake", {63'd0, wakePulse}, 64'd0);
    rstN = 1'b1;
    ticks(10);  // reset leaves nothing armed
    chk("R9 no match after reset", {63'd0, softIrq}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, V_WR[i]);
      ticks(V_TK[i]);
      chk($sformatf("R2/R3 vector %0d", i), rdData, V_EXP[i]);
    end

    // R3: write in a tick cycle replaces the increment
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; wrSel = 1'b0; wrData = 64'h40;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    chk("R3 write beats tick", rdData, 64'h40);

    // R4/R5: count 10, limit 15 -> fires on the fifth tick
    wr(1'b0, 64'd10);
    wr(1'b1, 64'd15);
    ticks(4);
    chk("R5 not yet", {63'd0, softIrq}, 64'd0);
    ticks(1);
    chk("R5 soft set", {63'd0, softIrq}, 64'd1);
    chk("R5 wake", {63'd0, wakePulse}, 64'd1);
    chk("R5 count at match", rdData, 64'd15);
    @(negedge clk);
    chk("R5 wake one cycle", {63'd0, wakePulse}, 64'd0);
    wr(1'b1, 64'd200);  // R8: limit write leaves soft set
    chk("R8 limit write keeps soft", {63'd0, softIrq}, 64'd1);
    clr();
    chk("R8 clear", {63'd0, softIrq}, 64'd0);
    wr(1'b1, 64'd15);
    ticks(1);  // re-armed at 15, count 16: fires late (R6 path)
    clr();
    ticks(5);
    chk("R5 one-shot", {63'd0, softIrq}, 64'd0);

    // R6: compare below count
    wr(1'b0, 64'd100);
    wr(1'b1, 64'd50);
    ticks(1);
    chk("R6 late compare fires", {63'd0, softIrq}, 64'd1);
    clr();

    // R7: zero compare, disabled compare, cancel
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd0);
    ticks(10);
    chk("R7 zero limit", {63'd0, softIrq}, 64'd0);
    wr(1'b0, 64'd0);
    wr(1'b1, 64'h8000_0000_0000_0005);
    ticks(10);
    chk("R7 disabled limit", {63'd0, softIrq}, 64'd0);
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd20);
    wr(1'b1, 64'h8000_0000_0000_0014);
    ticks(30);
    chk("R7 cancel", {63'd0, softIrq}, 64'd0);

    // R8: match and clear in the same cycle
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd3);
    ticks(2);
    @(negedge clk);
    tickEn = 1'b1; softClr = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; softClr = 1'b0;
    chk("R8 set wins over clear", {63'd0, softIrq}, 64'd1);
    clr();
    chk("R8 cleared after", {63'd0, softIrq}, 64'd0);

    // R9: reset cancels an armed match
    wr(1'b0, 64'd0);
    wr(1'b1, 64'd5);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 read after reset", rdData, 64'h8000_0000_0000_0000);
    rstN = 1'b1;
    ticks(10);
    chk("R9 armed match cancelled", {63'd0, softIrq}, 64'd0);
    chk("R2 count after reset", rdData, 64'h8000_0000_0000_000A);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule